// File: doc/BRIEF.md
# Two-Read One-Write Replicated Memory

This block gives a client two independent read ports and one write port per clock while being built only from single-port RAM banks. Every row is held in four copies, arranged as two groups of two banks. Read port 0 is served only by group 0 and read port 1 only by group 1. Because one read and one write can land in the same group in the same cycle, each row has a small freshness table. Per group, the table records which of the two copies holds the current value of that row.

A write is sent to one bank in each group: the bank that the group's read is not using in that cycle. The table entry for the written row is then moved to that bank. A read always goes to the copy that the table marks as fresh, so no read returns stale data. A per-row written flag, cleared by reset, masks the read result to zero for rows that have not been written since reset. The logic therefore behaves as if all copies were zero, without clearing the RAM banks.

Top module: `rpm_mem2r1w`

## Requirements
- R1: After reset both read data outputs are zero, and reading any row not written since reset returns zero.
- R2: Read data for a read enabled at clock edge N appears on that port's data output after edge N and stays valid until the next enabled read on that port.
- R3: The two read ports work independently: different addresses on both ports in one cycle each return their own row's current value.
- R4: A read of a row in the same cycle as a write to that row returns the value held before the write.
- R5: A value written at edge N is returned by a read on either port enabled at edge N+1 or later.
- R6: While a port's read enable is low, its read data output does not change.
- R7: No single-port bank is asked to read and write in the same cycle; the write in each group goes to the copy the group's read is not using.
- R8: After several writes to one row, reads on both ports return the most recent value.
- R9: Both ports reading the same row in the same cycle both return its current value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en0 | input | 1 | Read enable, port 0 |
| rd_addr0 | input | $clog2(DEPTH) | Read row, port 0 |
| rd_data0 | output | DW | Read data, port 0, one cycle after enable |
| rd_en1 | input | 1 | Read enable, port 1 |
| rd_addr1 | input | $clog2(DEPTH) | Read row, port 1 |
| rd_data1 | output | DW | Read data, port 1, one cycle after enable |
| wr_en | input | 1 | Write enable |
| wr_addr | input | $clog2(DEPTH) | Write row |
| wr_data | input | DW | Write data |

## Verification
The assertions assume that addresses stay below DEPTH. They also assume that no read enable or write enable is raised while reset is held, because the bank port checks and the hold checks only start once reset is low. The stimulus always draws rows from the valid range and drives all enables low during reset. Random traffic with a fixed seed often aims reads and writes at the same row in one cycle, which drives the idle-copy steering hard. Directed steps add the reset, same-row, repeated-write and hold cases.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
  // one write port -> two copies per group
  localparam int COPIES = 2;
  localparam int CW     = $clog2(COPIES);
  typedef logic [CW-1:0] copy_t;

  // copy a write may use without colliding with the group's read
  function automatic copy_t idle_copy(input logic rd_busy, input copy_t rd_copy,
                                      input copy_t fresh);
    copy_t used;
    used = rd_busy ? rd_copy : fresh;
    return used ^ copy_t'(1);
  endfunction
endpackage

// File: rtl/rpm_bank.sv
module rpm_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (en) q <= mem[addr];
  end

  assign rdata = q;

  // R7
  single_port_chk: assert property (@(posedge clk) disable iff (rst) !(en && we))
    else $error("bank read and write in one cycle");
endmodule

// File: rtl/rpm_ptr_table.sv
module rpm_ptr_table
  import rpm_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int GROUPS = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [GROUPS-1:0][AW-1:0]  rd_addr,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  copy_t [GROUPS-1:0]         wr_copy,
  output copy_t [GROUPS-1:0]         rd_copy,
  output logic  [GROUPS-1:0]         rd_written,
  output copy_t [GROUPS-1:0]         wr_fresh
);
  copy_t [GROUPS-1:0] fresh_q [DEPTH];
  logic  [DEPTH-1:0]  written_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      for (int r = 0; r < DEPTH; r++) fresh_q[r] <= '0;
    end else if (wr_en) begin
      written_q[wr_addr] <= 1'b1;
      fresh_q[wr_addr]   <= wr_copy;
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_look
    assign rd_copy[g]    = fresh_q[rd_addr[g]][g];
    assign rd_written[g] = written_q[rd_addr[g]];
    assign wr_fresh[g]   = fresh_q[wr_addr][g];
  end
endmodule

// File: rtl/rpm_group.sv
module rpm_group
  import rpm_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  copy_t         rd_copy,
  input  logic          rd_written,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  copy_t         wr_fresh,
  output copy_t         wr_copy,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] bank_q [COPIES];
  copy_t         sel_q;
  logic          vld_q;

  assign wr_copy = idle_copy(rd_en, rd_copy, wr_fresh);

  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    logic          b_en, b_we;
    logic [AW-1:0] b_addr;
    assign b_en   = rd_en && (rd_copy == copy_t'(c));
    assign b_we   = wr_en && (wr_copy == copy_t'(c));
    assign b_addr = b_we ? wr_addr : rd_addr;
    rpm_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
      .clk(clk), .rst(rst), .en(b_en), .we(b_we),
      .addr(b_addr), .wdata(wr_data), .rdata(bank_q[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      vld_q <= 1'b0;
    end else if (rd_en) begin
      sel_q <= rd_copy;
      vld_q <= rd_written;
    end
  end

  assign rd_data = vld_q ? bank_q[sel_q] : '0;

  // R7
  idle_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && wr_en) |-> (wr_copy != rd_copy))
    else $error("write steered onto the copy being read");
endmodule

// File: rtl/rpm_mem2r1w.sv
module rpm_mem2r1w
  import rpm_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int GROUPS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en0,
  input  logic [AW-1:0] rd_addr0,
  output logic [DW-1:0] rd_data0,
  input  logic          rd_en1,
  input  logic [AW-1:0] rd_addr1,
  output logic [DW-1:0] rd_data1,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  logic [GROUPS-1:0]         ren;
  logic [GROUPS-1:0][AW-1:0] raddr;
  logic [DW-1:0]             rdat [GROUPS];
  copy_t [GROUPS-1:0]        rcopy, wcopy, wfresh;
  logic  [GROUPS-1:0]        rwritten;

  assign ren   = {rd_en1, rd_en0};
  assign raddr = {rd_addr1, rd_addr0};

  rpm_ptr_table #(.DEPTH(DEPTH), .GROUPS(GROUPS)) u_table (
    .clk(clk), .rst(rst), .rd_addr(raddr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_copy(wcopy), .rd_copy(rcopy), .rd_written(rwritten), .wr_fresh(wfresh)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    rpm_group #(.DW(DW), .DEPTH(DEPTH)) u_grp (
      .clk(clk), .rst(rst), .rd_en(ren[g]), .rd_addr(raddr[g]),
      .rd_copy(rcopy[g]), .rd_written(rwritten[g]), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_fresh(wfresh[g]),
      .wr_copy(wcopy[g]), .rd_data(rdat[g])
    );
  end

  assign rd_data0 = rdat[0];
  assign rd_data1 = rdat[1];

  // R1
  unwritten_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en0 && !rwritten[0]) |=> (rd_data0 == '0))
    else $error("unwritten row read nonzero");
  // R6
  hold0_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_en0 && !$past(rst)) |=> $stable(rd_data0))
    else $error("port 0 data moved without a read");
  // R6
  hold1_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_en1 && !$past(rst)) |=> $stable(rd_data1))
    else $error("port 1 data moved without a read");
endmodule

// File: tb/rpm_mem2r1w_tb.sv
module rpm_mem2r1w_tb;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic rd_en0 = 0, rd_en1 = 0, wr_en = 0;
  logic [AW-1:0] rd_addr0 = '0, rd_addr1 = '0, wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data0, rd_data1;

  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] exp0 = '0, exp1 = '0;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rpm_mem2r1w #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .rd_en0(rd_en0), .rd_addr0(rd_addr0), .rd_data0(rd_data0),
    .rd_en1(rd_en1), .rd_addr1(rd_addr1), .rd_data1(rd_data1),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    return ref_mem[a];
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic e0, input logic [AW-1:0] a0,
                      input logic e1, input logic [AW-1:0] a1,
                      input logic we, input logic [AW-1:0] wa,
                      input logic [DW-1:0] wd, input string tag);
    rd_en0 = e0; rd_addr0 = a0; rd_en1 = e1; rd_addr1 = a1;
    wr_en = we; wr_addr = wa; wr_data = wd;
    if (e0) exp0 = model_read(a0);
    if (e1) exp1 = model_read(a1);
    if (we) ref_mem[wa] = wd;
    @(posedge clk); #1;
    check({tag, " port0"}, rd_data0, exp0);
    check({tag, " port1"}, rd_data1, exp1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    int seed = 32'h1d2c;
    void'($urandom(seed));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1: outputs zero right after reset
    check("R1 reset port0", rd_data0, '0);
    check("R1 reset port1", rd_data1, '0);
    step(1, 4, 1, 9, 0, 0, 0, "R1 unwritten rows");
    // R4: same-row read during write returns old value on both ports
    step(1, 3, 1, 3, 1, 3, 16'hA5A5, "R4 same row old");
    // R5 R9: new value visible next cycle on both ports, same row
    step(1, 3, 1, 3, 0, 0, 0, "R5 R9 new value");
    // R3: different rows, port0 reads row being rewritten
    step(1, 3, 1, 5, 1, 3, 16'h1234, "R4 R3 rewrite");
    step(1, 5, 1, 3, 1, 5, 16'h7777, "R3 R5 cross ports");
    step(1, 5, 1, 3, 0, 0, 0, "R3 R5 after");
    // R6: enables low, writes land on the rows last read, data holds
    step(0, 0, 0, 0, 1, 5, 16'hBEEF, "R6 hold0");
    step(0, 0, 0, 0, 1, 3, 16'hCAFE, "R6 hold1");
    // R2: one-cycle latency check after hold
    step(1, 5, 0, 0, 0, 0, 0, "R2 latency");
    // R8: repeated writes to one row with reads alternating ports
    for (int k = 0; k < 6; k++)
      step(k[0], 7, !k[0], 7, 1, 7, DW'(16'h0100 + k), "R8 repeat write");
    step(1, 7, 1, 7, 0, 0, 0, "R8 latest");
    // R7: write with no read present, then reads of the rows it touched
    step(0, 0, 0, 0, 1, 0, 16'h00F0, "R7 idle write");
    step(1, 0, 1, 0, 1, 0, 16'h0F00, "R7 read during write");
    step(1, 0, 1, DEPTH-1, 0, 0, 0, "R7 R1 top row");
    // random mix, addresses concentrated to force collisions
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a0, a1, wa;
      a0 = AW'($urandom_range(0, 5));
      a1 = ($urandom_range(0, 3) == 0) ? a0 : AW'($urandom_range(0, DEPTH-1));
      wa = ($urandom_range(0, 1) == 0) ? a0 : AW'($urandom_range(0, 5));
      step($urandom_range(0, 9) < 7, a0, $urandom_range(0, 9) < 7, a1,
           $urandom_range(0, 1) == 1, wa, DW'($urandom), "R3 R4 R5 R6 R8 random");
    end
    finish_run();
  end
endmodule